// File: doc/BRIEF.md
# Column Hit Sparsifier and Compactor

The block scans a pixel hit matrix one macro-column at a time and turns the scattered hit flags into a dense stream of coordinate words. The matrix is 128 columns by 32 rows. It is tiled into 4x4 macro-pixels, which gives 32 macro-columns and 8 macro-rows. The block drives the index of a macro-column. It receives the 32 row flags of all four columns of that macro-column in parallel, and it captures them in a single sweep cycle. The matrix uses this same cycle to clear the macro-column that was read. The captured flags are then drained column by column. Each data cycle takes the lowest-numbered remaining hits of the current column, up to eight of them, and packs them into adjacent output lanes starting at lane 0. The row they came from makes no difference to the lane they land in.

Each output word holds the frame's 8-bit time stamp, which is latched when the scan starts, and the hit's position split into macro-pixel and intra-macro-pixel fields. A column mask removes the hits of chosen columns. A column with no hits spends no data cycle. The downstream buffer reports how much free space it has. When that space is smaller than the pending word count, the block holds its state until the words fit.

Top module: `sprs_column_compactor`

## Requirements
- R1: While rst_ni is low, and after release until a scan starts, busy_o, sweep_rst_o and wr_o are 0 and out_cnt_o and out_word_o are all zeros. A reset during a scan abandons that scan.
- R2: A start_i pulse while idle captures ts_i. Every word of that scan carries this value in bits [19:12]. Changes on start_i and ts_i while busy_o is high have no effect.
- R3: Word bits are: [11:7] macro-column (column/4), [6:4] macro-row (row/4), [3:2] column mod 4, [1:0] row mod 4.
- R4: Lanes 0 to out_cnt_o-1 carry words and the upper lanes are zero. Lane j sits at out_word_o[20j+19:20j]. Words leave in ascending macro-column order, then ascending column within the macro-column, then ascending row.
- R5: A write carries min(8, hits remaining in the current column) words and never mixes columns. A column with n hits therefore takes ceil(n/8) writes.
- R6: Each macro-column gets exactly one sweep cycle, with sweep_rst_o high and mc_sel_o equal to its index, in the order 0 to 31. A sweep cycle emits no words.
- R7: Setting col_mask_i[c] to 1 removes every hit of column c from the output.
- R8: Columns and macro-columns without hits cost no data cycle. A scan keeps busy_o high for exactly 32 + writes + stall cycles.
- R9: wr_o is 1 exactly when out_cnt_o > 0 and buf_free_i >= out_cnt_o. In a stall cycle the words and count are held into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a scan (sampled while idle) |
| ts_i | input | 8 | Time stamp captured at start |
| col_mask_i | input | 128 | Per-column suppression, 1 = masked |
| mc_sel_o | output | 5 | Macro-column being read |
| sweep_rst_o | output | 1 | Capture-and-clear cycle of the selected macro-column |
| mc_hits_i | input | 128 | Row flags, bit k*32+r = column k of the macro-column, row r |
| buf_free_i | input | 6 | Free slots reported by the downstream buffer |
| wr_o | output | 1 | Words on the lanes are written this cycle |
| out_cnt_o | output | 4 | Number of valid lanes |
| out_word_o | output | 160 | Eight 20-bit hit words |
| busy_o | output | 1 | Scan in progress |

## Verification
The hardest case is a stall that lands on a column holding more than eight hits, while the free-space input sits exactly at the pending count or one below it. That situation needs dense columns, a busy buffer and a boundary count all in the same cycle. The bench builds dense frames from a hash-driven hit density. Across several frames it draws the free-space input from a small range around eight, so equality, shortfall and split columns all come together. A reference queue built from the requirements then catches any word that is lost, duplicated or reordered across a held cycle.

// File: rtl/sprs_pkg.sv
package sprs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_EMIT  = 2'd2
  } sprs_state_e;
endpackage

// File: rtl/sprs_col_select.sv
// Picks the lowest-indexed column that still holds pending hits.
module sprs_col_select #(
  parameter int COLS = 4,
  parameter int ROWS = 32
) (
  input  logic [COLS*ROWS-1:0]     pend_i,
  output logic [$clog2(COLS)-1:0]  idx_o,
  output logic [ROWS-1:0]          bits_o
);
  localparam int IW = $clog2(COLS);

  always_comb begin
    idx_o  = '0;
    bits_o = '0;
    for (int k = COLS - 1; k >= 0; k--) begin
      if (|pend_i[k*ROWS +: ROWS]) begin
        idx_o  = IW'(k);
        bits_o = pend_i[k*ROWS +: ROWS];
      end
    end
  end
endmodule

// File: rtl/sprs_lane_pick.sv
// Peels up to LANES set bits off a row vector, lowest row first.
module sprs_lane_pick #(
  parameter int ROWS  = 32,
  parameter int LANES = 8
) (
  input  logic [ROWS-1:0]                bits_i,
  output logic [LANES-1:0]               lane_vld_o,
  output logic [LANES*$clog2(ROWS)-1:0]  lane_row_o,
  output logic [$clog2(LANES+1)-1:0]     cnt_o,
  output logic [ROWS-1:0]                taken_o
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(LANES + 1);

  logic [ROWS-1:0] rem [LANES+1];
  assign rem[0] = bits_i;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [ROWS-1:0] onehot;
    logic [RW-1:0]   row_idx;
    assign onehot     = rem[j] & (~rem[j] + 1'b1);
    assign rem[j+1]   = rem[j] & ~onehot;
    assign lane_vld_o[j] = |rem[j];
    always_comb begin
      row_idx = '0;
      for (int r = 0; r < ROWS; r++) begin
        if (onehot[r]) row_idx = RW'(r);
      end
    end
    assign lane_row_o[j*RW +: RW] = row_idx;
  end

  assign taken_o = bits_i & ~rem[LANES];
  assign cnt_o   = CW'($countones(lane_vld_o));
endmodule

// File: rtl/sprs_word_pack.sv
// Formats each lane: {ts, macro-col, macro-row, col offset, row offset}.
module sprs_word_pack #(
  parameter int LANES = 8,
  parameter int TS_W  = 8,
  parameter int MC_W  = 5,
  parameter int OFF_W = 2,
  parameter int ROW_W = 5
) (
  input  logic [TS_W-1:0]                     ts_i,
  input  logic [MC_W-1:0]                     mc_i,
  input  logic [OFF_W-1:0]                    col_off_i,
  input  logic [LANES*ROW_W-1:0]              lane_row_i,
  input  logic [LANES-1:0]                    lane_en_i,
  output logic [LANES*(TS_W+MC_W+OFF_W+ROW_W)-1:0] words_o
);
  localparam int WORD_W = TS_W + MC_W + OFF_W + ROW_W;

  for (genvar j = 0; j < LANES; j++) begin : g_fmt
    logic [ROW_W-1:0]  row;
    logic [WORD_W-1:0] word;
    assign row  = lane_row_i[j*ROW_W +: ROW_W];
    assign word = {ts_i, mc_i, row[ROW_W-1:OFF_W], col_off_i, row[OFF_W-1:0]};
    assign words_o[j*WORD_W +: WORD_W] = lane_en_i[j] ? word : '0;
  end
endmodule

// File: rtl/sprs_column_compactor.sv
module sprs_column_compactor
  import sprs_pkg::*;
#(
  parameter int NUM_COLS = 128,
  parameter int NUM_ROWS = 32,
  parameter int MP_DIM   = 4,
  parameter int LANES    = 8,
  parameter int TS_W     = 8,
  parameter int FREE_W   = 6
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   start_i,
  input  logic [TS_W-1:0]                        ts_i,
  input  logic [NUM_COLS-1:0]                    col_mask_i,
  output logic [$clog2(NUM_COLS/MP_DIM)-1:0]     mc_sel_o,
  output logic                                   sweep_rst_o,
  input  logic [MP_DIM*NUM_ROWS-1:0]             mc_hits_i,
  input  logic [FREE_W-1:0]                      buf_free_i,
  output logic                                   wr_o,
  output logic [$clog2(LANES+1)-1:0]             out_cnt_o,
  output logic [LANES*(TS_W+$clog2(NUM_COLS)+$clog2(NUM_ROWS))-1:0] out_word_o,
  output logic                                   busy_o
);
  localparam int MC_CNT = NUM_COLS / MP_DIM;
  localparam int MC_W   = $clog2(MC_CNT);
  localparam int OFF_W  = $clog2(MP_DIM);
  localparam int ROW_W  = $clog2(NUM_ROWS);
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int MCB    = MP_DIM * NUM_ROWS;
  localparam int WORD_W = TS_W + MC_W + OFF_W + ROW_W;

  sprs_state_e        state_q, state_d;
  logic [MC_W-1:0]    mc_q, mc_d;
  logic [TS_W-1:0]    ts_q, ts_d;
  logic [MCB-1:0]     pend_q, pend_d, pend_left;
  logic [MCB-1:0]     masked_hits, clr_bits;
  logic [MP_DIM-1:0]  col_msk;
  logic [OFF_W-1:0]   col_idx;
  logic [NUM_ROWS-1:0] col_bits, taken;
  logic [LANES-1:0]   lane_vld;
  logic [LANES*ROW_W-1:0] lane_row;
  logic [CNT_W-1:0]   pick_cnt;
  logic               emit, fits, last_mc;

  // Apply column mask while capturing the selected macro-column.
  for (genvar k = 0; k < MP_DIM; k++) begin : g_col
    assign col_msk[k] = col_mask_i[{mc_q, OFF_W'(k)}];
    assign masked_hits[k*NUM_ROWS +: NUM_ROWS] =
        mc_hits_i[k*NUM_ROWS +: NUM_ROWS] & {NUM_ROWS{~col_msk[k]}};
    assign clr_bits[k*NUM_ROWS +: NUM_ROWS] =
        (col_idx == OFF_W'(k)) ? taken : '0;
  end

  sprs_col_select #(
    .COLS (MP_DIM),
    .ROWS (NUM_ROWS)
  ) u_col_sel (
    .pend_i (pend_q),
    .idx_o  (col_idx),
    .bits_o (col_bits)
  );

  sprs_lane_pick #(
    .ROWS  (NUM_ROWS),
    .LANES (LANES)
  ) u_pick (
    .bits_i     (col_bits),
    .lane_vld_o (lane_vld),
    .lane_row_o (lane_row),
    .cnt_o      (pick_cnt),
    .taken_o    (taken)
  );

  sprs_word_pack #(
    .LANES (LANES),
    .TS_W  (TS_W),
    .MC_W  (MC_W),
    .OFF_W (OFF_W),
    .ROW_W (ROW_W)
  ) u_pack (
    .ts_i       (ts_q),
    .mc_i       (mc_q),
    .col_off_i  (col_idx),
    .lane_row_i (lane_row),
    .lane_en_i  (lane_vld & {LANES{emit}}),
    .words_o    (out_word_o)
  );

  assign emit      = (state_q == ST_EMIT);
  assign fits      = int'(buf_free_i) >= int'(pick_cnt);
  assign last_mc   = (mc_q == MC_W'(MC_CNT - 1));
  assign pend_left = pend_q & ~clr_bits;

  always_comb begin
    state_d = state_q;
    mc_d    = mc_q;
    ts_d    = ts_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ts_d    = ts_i;
          mc_d    = '0;
          state_d = ST_SWEEP;
        end
      end
      ST_SWEEP: begin
        pend_d = masked_hits;
        if (|masked_hits)  state_d = ST_EMIT;
        else if (last_mc)  state_d = ST_IDLE;
        else               mc_d    = mc_q + 1'b1;
      end
      ST_EMIT: begin
        if (fits) begin
          pend_d = pend_left;
          if (pend_left == '0) begin
            if (last_mc) begin
              state_d = ST_IDLE;
            end else begin
              mc_d    = mc_q + 1'b1;
              state_d = ST_SWEEP;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mc_q    <= '0;
      ts_q    <= '0;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      mc_q    <= mc_d;
      ts_q    <= ts_d;
      pend_q  <= pend_d;
    end
  end

  assign mc_sel_o    = mc_q;
  assign sweep_rst_o = (state_q == ST_SWEEP);
  assign busy_o      = (state_q != ST_IDLE);
  assign out_cnt_o   = emit ? pick_cnt : '0;
  assign wr_o        = emit && fits;
endmodule

// File: rtl/sprs_column_compactor_chk.sv
module sprs_column_compactor_chk #(
  parameter int LANES  = 8,
  parameter int TS_W   = 8,
  parameter int FREE_W = 6,
  parameter int WORD_W = 20
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        busy_o,
  input logic                        sweep_rst_o,
  input logic                        wr_o,
  input logic [$clog2(LANES+1)-1:0]  out_cnt_o,
  input logic [LANES*WORD_W-1:0]     out_word_o,
  input logic [FREE_W-1:0]           buf_free_i,
  input logic [TS_W-1:0]             ts_q
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (out_cnt_o == '0 && !wr_o && !sweep_rst_o && out_word_o == '0));

  p_ts_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(ts_q));

  p_cnt_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(out_cnt_o) <= LANES);

  p_sweep_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_rst_o |-> (busy_o && out_cnt_o == '0 && !wr_o));

  p_wr_fit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (out_cnt_o != '0 && int'(buf_free_i) >= int'(out_cnt_o)));

  p_no_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_cnt_o != '0 && int'(buf_free_i) >= int'(out_cnt_o)) |-> wr_o);

  p_stall_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_cnt_o != '0 && !wr_o) |=> ($stable(out_word_o) && $stable(out_cnt_o)));
endmodule

bind sprs_column_compactor sprs_column_compactor_chk #(
  .LANES  (LANES),
  .TS_W   (TS_W),
  .FREE_W (FREE_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .sweep_rst_o (sweep_rst_o),
  .wr_o        (wr_o),
  .out_cnt_o   (out_cnt_o),
  .out_word_o  (out_word_o),
  .buf_free_i  (buf_free_i),
  .ts_q        (ts_q)
);

// File: tb/tb_sprs_column_compactor.sv
module tb_sprs_column_compactor;
  localparam int NC = 128, NR = 32, MPD = 4, LN = 8, WW = 20, NMC = 32;

  typedef struct packed {
    logic [15:0] seed;
    logic [5:0]  dens;     // hit if hash%32 < dens
    logic [1:0]  mask_md;  // 0 none,1 even cols,2 all but col 5,3 upper half
    logic        stall;
    logic        restart;  // start pulse mid-scan
    logic [7:0]  ts;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'd1, 6'd0,  2'd0, 1'b0, 1'b0, 8'h11},
    '{16'd2, 6'd32, 2'd0, 1'b0, 1'b0, 8'h22},
    '{16'd3, 6'd3,  2'd0, 1'b0, 1'b0, 8'h33},
    '{16'd4, 6'd10, 2'd1, 1'b0, 1'b0, 8'h44},
    '{16'd5, 6'd6,  2'd2, 1'b1, 1'b0, 8'h55},
    '{16'd6, 6'd16, 2'd3, 1'b1, 1'b1, 8'h66},
    '{16'd7, 6'd28, 2'd0, 1'b1, 1'b0, 8'h77},
    '{16'd8, 6'd20, 2'd0, 1'b0, 1'b1, 8'h88}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] ts = '0;
  logic [NC-1:0] mask = '0;
  logic [4:0] mc_sel;
  logic sweep, wr, busy;
  logic [MPD*NR-1:0] mc_hits;
  logic [5:0] free = 6'd63;
  logic [3:0] cnt;
  logic [LN*WW-1:0] words;

  logic [NR-1:0] mat [NC];
  logic [WW-1:0] exp_w [4096];
  int            exp_c [2048];
  logic [WW-1:0] got_w [4096];
  int            got_c [2048];
  int n_w, n_wr, g_w, g_wr, total = 0, bad = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #5 clk = ~clk;

  always_comb
    for (int k = 0; k < MPD; k++) mc_hits[k*NR +: NR] = mat[int'(mc_sel)*MPD + k];

  sprs_column_compactor dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ts_i(ts), .col_mask_i(mask),
    .mc_sel_o(mc_sel), .sweep_rst_o(sweep), .mc_hits_i(mc_hits), .buf_free_i(free),
    .wr_o(wr), .out_cnt_o(cnt), .out_word_o(words), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned hsh(int c, int r, int s);
    int unsigned x;
    x = s * 32'h9E3779B1 ^ c * 32'h85EBCA6B ^ r * 32'hC2B2AE35;
    x ^= x >> 15; x *= 32'h2C1B3C6D; x ^= x >> 12;
    return x;
  endfunction

  function automatic logic [WW-1:0] mkw(logic [7:0] t, int c, int r);
    return {t, 5'(c / 4), 3'(r / 4), 2'(c % 4), 2'(r % 4)};
  endfunction

  // Reference queue straight from R3..R7.
  task automatic build_exp(input logic [7:0] t);
    n_w = 0; n_wr = 0;
    for (int c = 0; c < NC; c++) begin
      int left = 0;
      if (!mask[c]) begin
        for (int r = 0; r < NR; r++)
          if (mat[c][r]) begin exp_w[n_w] = mkw(t, c, r); n_w++; left++; end
        while (left > 0) begin
          exp_c[n_wr] = (left > LN) ? LN : left; left -= exp_c[n_wr]; n_wr++;
        end
      end
    end
  endtask

  task automatic run_scan(input logic [7:0] t, input bit stall, input bit restart);
    int cyc = 0, stalls = 0, sw = 0;
    build_exp(t);
    g_w = 0; g_wr = 0;
    @(negedge clk); start = 1'b1; ts = t;
    @(negedge clk); start = 1'b0; ts = ~t;
    forever begin
      if (stall) begin lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; free = 6'(lfsr[7:0] % 12); end
      else free = 6'd63;
      #1;
      if (!busy) break;
      cyc++;
      if (restart) begin start = (cyc == 3); ts = 8'h5A; end
      if (sweep) begin
        chk(mc_sel == 5'(sw), "R6 sweep order", mc_sel, sw);
        chk(cnt == 0, "R6 sweep emits nothing", cnt, 0);
        sw++;
      end
      if (cnt != 0) begin
        chk(wr == (int'(free) >= int'(cnt)), "R9 write gating", wr, int'(free) >= int'(cnt));
        if (wr) begin
          chk(int'(cnt) == exp_c[g_wr], "R5 write size", cnt, exp_c[g_wr]);
          got_c[g_wr] = cnt;
          for (int j = 0; j < LN; j++) begin
            if (j < int'(cnt)) begin
              got_w[g_w] = words[j*WW +: WW];
              chk(words[j*WW +: WW] == exp_w[g_w], "R2/R3/R4/R7 word", words[j*WW +: WW], exp_w[g_w]);
              g_w++;
            end else chk(words[j*WW +: WW] == '0, "R4 upper lane zero", words[j*WW +: WW], 0);
          end
          g_wr++;
        end else stalls++;
      end
      if (cyc > 8000) begin chk(0, "watchdog scan", cyc, 0); break; end
      @(negedge clk);
    end
    start = 1'b0;
    chk(sw == NMC, "R6 sweep count", sw, NMC);
    chk(g_wr == n_wr, "R5 write count", g_wr, n_wr);
    chk(g_w == n_w, "R7 word count", g_w, n_w);
    chk(cyc == NMC + n_wr + stalls, "R8 busy cycles", cyc, NMC + n_wr + stalls);
  endtask

  initial begin
    #(200000 * 10);
    chk(0, "watchdog global", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) mat[c] = '0;
    // R1: reset state
    repeat (3) @(negedge clk);
    #1 chk(!busy && !sweep && !wr && cnt == 0 && words == '0, "R1 in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !wr && cnt == 0, "R1 after release", busy, 0);

    foreach (VECS[i]) begin
      for (int c = 0; c < NC; c++) begin
        for (int r = 0; r < NR; r++) mat[c][r] = (hsh(c, r, int'(VECS[i].seed)) % 32) < VECS[i].dens;
        case (VECS[i].mask_md)
          2'd1: mask[c] = (c % 2 == 0);
          2'd2: mask[c] = (c != 5);
          2'd3: mask[c] = (c >= NC / 2);
          default: mask[c] = 1'b0;
        endcase
      end
      run_scan(VECS[i].ts, VECS[i].stall, VECS[i].restart);
    end

    // R3: hand-computed field positions
    mask = '0;
    for (int c = 0; c < NC; c++) mat[c] = '0;
    mat[0][0] = 1'b1; mat[66][9] = 1'b1; mat[127][31] = 1'b1;
    run_scan(8'hC3, 1'b0, 1'b0);
    chk(got_w[0] == {8'hC3, 5'd0, 3'd0, 2'd0, 2'd0}, "R3 corner low", got_w[0], {8'hC3, 12'd0});
    chk(got_w[1] == {8'hC3, 5'd16, 3'd2, 2'd2, 2'd1}, "R3 mid", got_w[1], {8'hC3, 5'd16, 3'd2, 2'd2, 2'd1});
    chk(got_w[2] == {8'hC3, 5'd31, 3'd7, 2'd3, 2'd3}, "R3 corner high", got_w[2], {8'hC3, 12'hFFF});
    chk(n_wr == 3, "R8 sparse scan writes", n_wr, 3);

    // R5: exactly 8 then 9 hits in neighbouring columns, R7 masked column
    for (int c = 0; c < NC; c++) mat[c] = '0;
    mat[10] = 32'h0000_00FF; mat[11] = 32'h8000_01FE; mat[12] = 32'hFFFF_FFFF; mask[12] = 1'b1;
    run_scan(8'h3C, 1'b1, 1'b0);
    chk(g_wr == 3 && got_c[0] == 8 && got_c[1] == 8 && got_c[2] == 1, "R5 split 8/9", got_c[2], 1);
    chk(got_w[16] == mkw(8'h3C, 11, 31), "R4 last row last", got_w[16], mkw(8'h3C, 11, 31));
    mask = '0;

    // R1: reset during a scan
    for (int c = 0; c < NC; c++) mat[c] = 32'hFFFF_FFFF;
    @(negedge clk); start = 1'b1; ts = 8'h99;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0; #1;
    chk(!busy && !wr && cnt == 0 && !sweep, "R1 mid-scan reset", busy, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && cnt == 0, "R1 stays idle", busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule